// File: doc/BRIEF.md
# Network Controller Interrupt Status and Mask Unit

This block gathers the seven event sources of a small network controller into one level-sensitive interrupt line. Each source raises a one-cycle set pulse from the receive engine, the transmit engine or the management and PHY logic. The pulse latches into a sticky raw-status bit. Software clears status bits by writing ones to the acknowledge register, and it gates which bits reach the interrupt line through a mask register. The interrupt line is high whenever a status bit and its mask bit are both set.

The register port has one write strobe, one read strobe and a byte address. Word offset zero is the status register on reads and the acknowledge register on writes. Word offset four is the mask register. Read data is registered. Writing a one to the transmit-error position of the acknowledge register also sends a one-cycle strobe to the transmit frame assembler. The strobe returns that assembler to its idle state, where it waits for a length word.

Top module: `netc_irq_ctrl`

## Requirements
- R1: After a synchronous reset the status is 0, the mask is 0x7F, and `irq`, `framer_rst` and `reg_rdata` are all 0.
- R2: A set pulse on `evt_set[i]` sets status bit i, and the bit stays set until it is acknowledged. The bit positions are: 0 receive done, 1 transmit error, 2 transmit empty, 3 FIFO overrun, 4 receive error, 5 management done, 6 PHY event.
- R3: A write to offset 0x0 clears each status bit whose bit is one in `reg_wdata[6:0]` and leaves the other status bits unchanged.
- R4: When a set pulse and an acknowledge of the same bit arrive in the same cycle, the bit ends up set.
- R5: `irq` is a registered output equal to the OR of (status AND mask). It takes its new value on the same clock edge that updates the status or the mask.
- R6: A write to offset 0x4 replaces the whole mask with `reg_wdata[6:0]`. The mask has no effect on the status value that is read back.
- R7: A read presents its data on `reg_rdata` one cycle after `reg_rd`. The data is the raw status (offset 0x0) or the mask (offset 0x4), zero-extended to 32 bits. Any other offset reads 0.
- R8: An acknowledge write with `reg_wdata[1]` = 1 makes `framer_rst` high for exactly the one cycle after the write edge. This happens whether or not status bit 1 was set. No other write produces the strobe.
- R9: Writes to offsets other than 0x0 and 0x4 have no effect. Written bits above bit 6 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| evt_set | input | 7 | One-cycle set pulses, one per event source |
| irq | output | 1 | Level interrupt request |
| framer_rst | output | 1 | One-cycle reset strobe to the transmit frame assembler |

## Verification
The hardest case to reach is a set pulse and an acknowledge of the same bit landing on one clock edge, because the event side and the register side are driven independently. The bench drives both `evt_set` and an acknowledge write at the same falling edge. It then reads the status back to confirm that the bit survived, while a second acknowledged bit with no set pulse was cleared. The bench also checks the strobe in the exact cycle after an acknowledge write, with the status bit already clear, and again after a mask write that carries the same bit pattern.

// File: rtl/netc_irq_pkg.sv
package netc_irq_pkg;
  localparam int SRC_N      = 7;
  localparam int WORD_W     = 32;
  localparam int BADDR_W    = 6;
  localparam int OFS_STATUS = 0;
  localparam int OFS_MASK   = 4;
  localparam int TXERR_POS  = 1;

  typedef enum logic [1:0] {
    RSEL_NONE   = 2'd0,
    RSEL_STATUS = 2'd1,
    RSEL_MASK   = 2'd2
  } rsel_e;
endpackage

// File: rtl/netc_irq_regport.sv
module netc_irq_regport
  import netc_irq_pkg::*;
#(
  parameter int NUM_SRC  = SRC_N,
  parameter int DATA_W   = WORD_W,
  parameter int ADDR_W   = BADDR_W,
  parameter int STAT_OFS = OFS_STATUS,
  parameter int MASK_OFS = OFS_MASK,
  parameter int RST_POS  = TXERR_POS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [NUM_SRC-1:0] status_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic [NUM_SRC-1:0] clr_o,
  output logic               mask_we_o,
  output logic [NUM_SRC-1:0] mask_wd_o,
  output logic               strobe_req_o,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);
  localparam int PAD_W = DATA_W - NUM_SRC;

  logic  ack_hit;
  logic  rsel_hit;
  rsel_e rsel;
  logic  [DATA_W-1:0] rdata_q;
  logic  [DATA_W-1:0] rmux;
  logic  unused_hi;

  assign unused_hi    = ^wdata_i[DATA_W-1:NUM_SRC];
  assign ack_hit      = wr_i && (addr_i == STAT_A);
  assign mask_we_o    = wr_i && (addr_i == MASK_A);
  assign mask_wd_o    = wdata_i[NUM_SRC-1:0];
  assign clr_o        = ack_hit ? wdata_i[NUM_SRC-1:0] : '0;
  assign strobe_req_o = ack_hit && wdata_i[RST_POS];
  assign rsel_hit     = rd_i;

  always_comb begin
    if (addr_i == STAT_A)      rsel = RSEL_STATUS;
    else if (addr_i == MASK_A) rsel = RSEL_MASK;
    else                       rsel = RSEL_NONE;
  end

  always_comb begin
    unique case (rsel)
      RSEL_STATUS: rmux = {{PAD_W{1'b0}}, status_i};
      RSEL_MASK:   rmux = {{PAD_W{1'b0}}, mask_i};
      default:     rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           rdata_q <= '0;
    else if (rsel_hit) rdata_q <= rmux;
  end

  assign rdata_o = rdata_q;

  // R7
  stat_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && addr_i == STAT_A) |=> (rdata_o == {{PAD_W{1'b0}}, $past(status_i)}));

  // R7
  other_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && addr_i != STAT_A && addr_i != MASK_A) |=> (rdata_o == '0));
endmodule

// File: rtl/netc_irq_status_bank.sv
module netc_irq_status_bank
  import netc_irq_pkg::*;
#(
  parameter int NUM_SRC = SRC_N
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] st_q_o,
  output logic [NUM_SRC-1:0] st_d_o
);
  logic [NUM_SRC-1:0] st_q;
  logic [NUM_SRC-1:0] st_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
    // set has priority over a same-cycle clear
    assign st_d[i] = set_i[i] | (st_q[i] & ~clr_i[i]);

    always_ff @(posedge clk) begin
      if (rst) st_q[i] <= 1'b0;
      else     st_q[i] <= st_d[i];
    end

    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (st_q[i] && !clr_i[i]) |=> st_q[i]);

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      set_i[i] |=> st_q[i]);

    // R3
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_i[i] && !set_i[i]) |=> !st_q[i]);
  end

  assign st_q_o = st_q;
  assign st_d_o = st_d;
endmodule

// File: rtl/netc_irq_mask_reg.sv
module netc_irq_mask_reg
  import netc_irq_pkg::*;
#(
  parameter int                 NUM_SRC  = SRC_N,
  parameter logic [NUM_SRC-1:0] MASK_RST = '1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we_i,
  input  logic [NUM_SRC-1:0] wd_i,
  output logic [NUM_SRC-1:0] mk_q_o,
  output logic [NUM_SRC-1:0] mk_d_o
);
  logic [NUM_SRC-1:0] mk_q;
  logic [NUM_SRC-1:0] mk_d;

  assign mk_d = we_i ? wd_i : mk_q;

  always_ff @(posedge clk) begin
    if (rst) mk_q <= MASK_RST;
    else     mk_q <= mk_d;
  end

  assign mk_q_o = mk_q;
  assign mk_d_o = mk_d;

  // R6
  mask_replace_chk: assert property (@(posedge clk) disable iff (rst)
    we_i |=> (mk_q == $past(wd_i)));

  // R9
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(mk_q));
endmodule

// File: rtl/netc_irq_out_gen.sv
module netc_irq_out_gen
  import netc_irq_pkg::*;
#(
  parameter int NUM_SRC = SRC_N
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] st_d_i,
  input  logic [NUM_SRC-1:0] mk_d_i,
  input  logic               strobe_req_i,
  output logic               irq_o,
  output logic               strobe_o
);
  logic irq_q;
  logic strobe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q    <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      irq_q    <= |(st_d_i & mk_d_i);
      strobe_q <= strobe_req_i;
    end
  end

  assign irq_o    = irq_q;
  assign strobe_o = strobe_q;

  // R8
  strobe_cause_chk: assert property (@(posedge clk) disable iff (rst)
    strobe_o |-> $past(strobe_req_i));
endmodule

// File: rtl/netc_irq_ctrl.sv
module netc_irq_ctrl
  import netc_irq_pkg::*;
#(
  parameter int NUM_SRC  = SRC_N,
  parameter int DATA_W   = WORD_W,
  parameter int ADDR_W   = BADDR_W,
  parameter int STAT_OFS = OFS_STATUS,
  parameter int MASK_OFS = OFS_MASK,
  parameter int RST_POS  = TXERR_POS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_SRC-1:0] evt_set,
  output logic               irq,
  output logic               framer_rst
);
  localparam logic [NUM_SRC-1:0] MASK_ALL = '1;

  logic [NUM_SRC-1:0] clr;
  logic               mask_we;
  logic [NUM_SRC-1:0] mask_wd;
  logic               strobe_req;
  logic [NUM_SRC-1:0] st_q;
  logic [NUM_SRC-1:0] st_d;
  logic [NUM_SRC-1:0] mk_q;
  logic [NUM_SRC-1:0] mk_d;

  netc_irq_regport #(
    .NUM_SRC (NUM_SRC),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .STAT_OFS(STAT_OFS),
    .MASK_OFS(MASK_OFS),
    .RST_POS (RST_POS)
  ) u_port (
    .clk         (clk),
    .rst         (rst),
    .wr_i        (reg_wr),
    .rd_i        (reg_rd),
    .addr_i      (reg_addr),
    .wdata_i     (reg_wdata),
    .status_i    (st_q),
    .mask_i      (mk_q),
    .clr_o       (clr),
    .mask_we_o   (mask_we),
    .mask_wd_o   (mask_wd),
    .strobe_req_o(strobe_req),
    .rdata_o     (reg_rdata)
  );

  netc_irq_status_bank #(.NUM_SRC(NUM_SRC)) u_status (
    .clk   (clk),
    .rst   (rst),
    .set_i (evt_set),
    .clr_i (clr),
    .st_q_o(st_q),
    .st_d_o(st_d)
  );

  netc_irq_mask_reg #(.NUM_SRC(NUM_SRC), .MASK_RST(MASK_ALL)) u_mask (
    .clk   (clk),
    .rst   (rst),
    .we_i  (mask_we),
    .wd_i  (mask_wd),
    .mk_q_o(mk_q),
    .mk_d_o(mk_d)
  );

  netc_irq_out_gen #(.NUM_SRC(NUM_SRC)) u_out (
    .clk         (clk),
    .rst         (rst),
    .st_d_i      (st_d),
    .mk_d_i      (mk_d),
    .strobe_req_i(strobe_req),
    .irq_o       (irq),
    .strobe_o    (framer_rst)
  );

  // R5
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (|(st_q & mk_q)));

  // R8
  strobe_src_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(STAT_OFS) && reg_wdata[RST_POS]) |=> framer_rst);
endmodule

// File: tb/test_netc_irq_ctrl.sv
module test_netc_irq_ctrl;
  localparam int NS = 7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NS-1:0] evt_set = '0;
  logic        irq;
  logic        framer_rst;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [NS-1:0] exp_st;
  logic [NS-1:0] exp_mk;

  always #4 clk = ~clk;

  netc_irq_ctrl i_netc_irq_ctrl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_set(evt_set), .irq(irq), .framer_rst(framer_rst)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [NS-1:0] v);
    @(negedge clk);
    evt_set = v;
    @(negedge clk);
    evt_set = '0;
    exp_st = exp_st | v;
  endtask

  task automatic chk_state(input string req);
    logic [31:0] d;
    rd(6'h00, d);
    chk(req, "status", d, {25'd0, exp_st});
    rd(6'h04, d);
    chk(req, "mask", d, {25'd0, exp_mk});
    chk(req, "irq", {31'd0, irq}, {31'd0, |(exp_st & exp_mk)});
  endtask

  task automatic t_reset;
    chk("R1", "irq after reset", {31'd0, irq}, 32'd0);
    chk("R1", "framer_rst after reset", {31'd0, framer_rst}, 32'd0);
    chk("R1", "rdata after reset", reg_rdata, 32'd0);
    chk_state("R1");
  endtask

  task automatic t_each_bit;
    for (int i = 0; i < NS; i++) begin
      pulse(NS'(1) << i);
      chk("R2", "irq right after set", {31'd0, irq}, 32'd1);
      chk_state("R2");
      wr(6'h00, 32'd1 << i);
      exp_st = '0;
      chk("R3", "irq right after ack", {31'd0, irq}, 32'd0);
      chk_state("R3");
      @(negedge clk);
    end
  endtask

  task automatic t_sticky_partial;
    pulse(7'h49);
    repeat (5) @(negedge clk);
    chk_state("R2");
    wr(6'h00, 32'h0000_0008);
    exp_st = 7'h41;
    chk_state("R3");
    wr(6'h00, 32'hFFFF_FF80);
    chk_state("R9");
    wr(6'h00, 32'h0000_0041);
    exp_st = '0;
    chk_state("R3");
  endtask

  task automatic t_collide;
    pulse(7'h01);
    @(negedge clk);
    evt_set = 7'h04;
    reg_wr = 1'b1; reg_addr = 6'h00; reg_wdata = 32'h0000_0005;
    @(negedge clk);
    evt_set = '0; reg_wr = 1'b0;
    exp_st = 7'h04;
    chk("R4", "irq after collide", {31'd0, irq}, 32'd1);
    chk_state("R4");
    wr(6'h00, 32'h0000_0004);
    exp_st = '0;
  endtask

  task automatic t_mask;
    pulse(7'h40);
    wr(6'h04, 32'h0000_0000);
    exp_mk = '0;
    chk("R5", "irq same edge as mask clear", {31'd0, irq}, 32'd0);
    chk_state("R6");
    wr(6'h04, 32'hFFFF_FF40);
    exp_mk = 7'h40;
    chk("R5", "irq same edge as mask set", {31'd0, irq}, 32'd1);
    chk_state("R6");
    pulse(7'h01);
    wr(6'h00, 32'h0000_0040);
    exp_st = 7'h01;
    chk("R5", "irq with only masked bit left", {31'd0, irq}, 32'd0);
    chk_state("R5");
    wr(6'h04, 32'h0000_007F);
    exp_mk = 7'h7F;
    chk_state("R6");
    wr(6'h00, 32'h0000_0001);
    exp_st = '0;
  endtask

  task automatic t_strobe;
    wr(6'h00, 32'h0000_0002);
    chk("R8", "strobe after txerr ack", {31'd0, framer_rst}, 32'd1);
    @(negedge clk);
    chk("R8", "strobe one cycle only", {31'd0, framer_rst}, 32'd0);
    pulse(7'h02);
    wr(6'h00, 32'h0000_0002);
    exp_st = '0;
    chk("R8", "strobe with bit set", {31'd0, framer_rst}, 32'd1);
    chk_state("R3");
    wr(6'h00, 32'h0000_0001);
    chk("R8", "no strobe without bit1", {31'd0, framer_rst}, 32'd0);
    wr(6'h04, 32'h0000_0002);
    exp_mk = 7'h02;
    chk("R8", "no strobe on mask write", {31'd0, framer_rst}, 32'd0);
    wr(6'h04, 32'h0000_007F);
    exp_mk = 7'h7F;
  endtask

  task automatic t_other;
    logic [31:0] d;
    pulse(7'h22);
    wr(6'h08, 32'hFFFF_FFFF);
    chk("R9", "no strobe on other offset", {31'd0, framer_rst}, 32'd0);
    wr(6'h0C, 32'h0000_0000);
    chk_state("R9");
    rd(6'h08, d);
    chk("R7", "other offset reads zero", d, 32'd0);
    rd(6'h00, d);
    chk("R7", "status zero-extended", d, 32'h0000_0022);
  endtask

  initial begin
    exp_st = '0;
    exp_mk = 7'h7F;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_each_bit();
    t_sticky_partial();
    t_collide();
    t_mask();
    t_strobe();
    t_other();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule